// File: doc/BRIEF.md
# Super-I/O Configuration Window

This block is a 256-entry, byte-wide configuration register file that a host reaches through a pair of adjacent I/O ports. A write to the lower port selects which register is current. A write to the upper port stores a byte into that register. A read of either port returns the byte held in that register. Most of the index space is read-only. Two locations that hold serial-port base values only accept their own default byte.

A level input from the host bridge opens the window. While it is low, the two ports ignore every access, and reads are not claimed. Read data comes from a register and is marked valid for one cycle, in the cycle after the read strobe.

Top module: `sio_cfg_window`

## Requirements
- R1: After a synchronous reset these registers hold the listed values: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE. The current index and every other register hold 0x00, and `io_rvalid` is low.
- R2: While the window is open, a write strobe at address 0x03F0 stores `io_wdata` as the current index. The new index is in effect from the next cycle.
- R3: While the window is open, a read strobe at 0x03F0 or 0x03F1 drives `io_rvalid` high for exactly the following cycle. In that cycle `io_rdata` equals the register at the current index.
- R4: While the window is open, a write strobe at 0x03F1 stores `io_wdata` into the register at the current index when that index is 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC.
- R5: A data-port write is dropped, and the register keeps its value, when the index is 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R6: A data-port write to index 0xE7 is stored only if the byte is 0xFE. A data-port write to index 0xE8 is stored only if the byte is 0xBE. Any other byte is dropped.
- R7: While `win_enable` is low, reads and writes at either port change no index or register, and `io_rvalid` stays low.
- R8: When a read and a data-port write hit the same register in one cycle, the read returns the value from before the write.
- R9: Accesses to any address other than 0x03F0 and 0x03F1 change nothing, and reads there are not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_enable | input | 1 | Window open (set by the host bridge) |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one byte |
| io_rd | input | 1 | Read strobe, one byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_rvalid | output | 1 | Read data valid, one cycle after a claimed read |

## Verification
The assertions check on every cycle that:
- the two serial-base registers never leave their fixed bytes;
- sample protected locations stay at zero;
- a valid pulse always traces back to a claimed read one cycle earlier;
- the index never moves without an open-window write.

Only the bench scenarios show the per-index write filter across all 256 entries, the reset contents, and the read-before-write ordering. The bench also shows that a closed window and foreign addresses leave the state untouched.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int IDX_W  = 8;
  localparam int DATA_W = 8;
  localparam int IO_AW  = 16;
  localparam int DEPTH  = 1 << IDX_W;

  localparam logic [IDX_W-1:0]  SER1_IDX = 8'hE7;
  localparam logic [IDX_W-1:0]  SER2_IDX = 8'hE8;
  localparam logic [DATA_W-1:0] SER1_VAL = 8'hFE;
  localparam logic [DATA_W-1:0] SER2_VAL = 8'hBE;

  function automatic logic [DATA_W-1:0] cfg_reset_value(input logic [IDX_W-1:0] idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      SER1_IDX: return SER1_VAL;
      SER2_IDX: return SER2_VAL;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'h03F0
) (
  input  logic [AW-1:0] addr,
  input  logic          enable,
  output logic          sel_index,
  output logic          sel_data
);
  localparam logic [AW-1:0] DATA_ADDR = BASE + AW'(1);

  always_comb begin
    sel_index = enable && (addr == BASE);
    sel_data  = enable && (addr == DATA_ADDR);
  end
endmodule

// File: rtl/sio_wr_filter.sv
module sio_wr_filter
  import sio_cfg_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] data,
  output logic              allow
);
  always_comb begin
    allow = 1'b1;
    if (idx <= 8'hDF)                         allow = 1'b0;
    else if (idx == 8'hE4 || idx == 8'hE5)    allow = 1'b0;
    else if (idx >= 8'hE9 && idx <= 8'hED)    allow = 1'b0;
    else if (idx == 8'hF3 || idx == 8'hF5 || idx == 8'hF7) allow = 1'b0;
    else if (idx >= 8'hF9 && idx <= 8'hFB)    allow = 1'b0;
    else if (idx >= 8'hFD)                    allow = 1'b0;
    else if (idx == SER1_IDX)                 allow = (data == SER1_VAL);
    else if (idx == SER2_IDX)                 allow = (data == SER2_VAL);
  end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= cfg_reset_value(IDX_W'(k));
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= mem[addr];
    end
  end

  AST_SERIAL_BASE_FIXED: assert property (@(posedge clk) disable iff (rst)
    mem[SER1_IDX] == SER1_VAL && mem[SER2_IDX] == SER2_VAL); // R6
  AST_LOCKED_STAY_ZERO: assert property (@(posedge clk) disable iff (rst)
    mem[8'h00] == '0 && mem[8'hF3] == '0 && mem[8'hFF] == '0); // R5
endmodule

// File: rtl/sio_cfg_window.sv
module sio_cfg_window
  import sio_cfg_pkg::*;
#(
  parameter logic [IO_AW-1:0] PORT_BASE = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_enable,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid
);
  logic             sel_index, sel_data;
  logic             allow;
  logic [IDX_W-1:0] cur_idx;
  logic             reg_we, reg_re;

  sio_port_decode #(.AW(IO_AW), .BASE(PORT_BASE)) i_decode (
    .addr(io_addr), .enable(win_enable),
    .sel_index(sel_index), .sel_data(sel_data)
  );

  sio_wr_filter i_filter (.idx(cur_idx), .data(io_wdata), .allow(allow));

  always_ff @(posedge clk) begin
    if (rst) cur_idx <= '0;
    else if (io_wr && sel_index) cur_idx <= io_wdata;
  end

  always_comb begin
    reg_we = io_wr && sel_data && allow;
    reg_re = io_rd && (sel_index || sel_data);
  end

  sio_cfg_regs i_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(cur_idx), .wdata(io_wdata),
    .re(reg_re), .rdata(io_rdata), .rvalid(io_rvalid)
  );

  AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(io_rd && win_enable)); // R3
  AST_CLOSED_NO_CLAIM: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !win_enable) |=> !io_rvalid); // R7
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && win_enable) |=> $stable(cur_idx)); // R2
endmodule

// File: tb/test_sio_cfg_window.sv
module test_sio_cfg_window;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic win_enable = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic io_rvalid;

  int vectors = 0, errors = 0;
  logic [7:0] mdl [256];
  logic [7:0] midx;

  always #2 clk = ~clk;

  sio_cfg_window i_sio_cfg_window (
    .clk(clk), .rst(rst), .win_enable(win_enable), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid)
  );

  function automatic bit may_write(input logic [7:0] i, input logic [7:0] d);
    case (i)
      8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'hEE, 8'hEF, 8'hF0,
      8'hF1, 8'hF2, 8'hF4, 8'hF6, 8'hF8, 8'hFC: return 1'b1;
      8'hE7: return d == 8'hFE;
      8'hE8: return d == 8'hBE;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input string tag, input logic [15:0] a, input bit wr,
                      input bit rd, input logic [7:0] wd, input bit en);
    bit ev;
    logic [7:0] ed;
    io_addr = a; io_wr = wr; io_rd = rd; io_wdata = wd; win_enable = en;
    ev = rd && en && (a == 16'h03F0 || a == 16'h03F1);
    ed = mdl[midx];
    if (wr && en && a == 16'h03F0) midx = wd;
    else if (wr && en && a == 16'h03F1 && may_write(midx, wd)) mdl[midx] = wd;
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (io_rvalid !== ev) begin
      errors++;
      $display("FAIL %s: rvalid actual %0b expected %0b", tag, io_rvalid, ev);
    end else if (ev && io_rdata !== ed) begin
      errors++;
      $display("FAIL %s: rdata actual %02h expected %02h", tag, io_rdata, ed);
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    mdl[8'hE0] = 8'h3C; mdl[8'hE2] = 8'h03; mdl[8'hE3] = 8'hFC;
    mdl[8'hE6] = 8'hDE; mdl[8'hE7] = 8'hFE; mdl[8'hE8] = 8'hBE;
    midx = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    vectors++;
    if (io_rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R1: rvalid actual %0b expected 0", io_rvalid);
    end
    // R1: reset contents, read through the data port from index 0 on
    step("R1", 16'h03F1, 0, 1, 8'h00, 1);
    for (int i = 0; i < 256; i++) begin
      step("R2", 16'h03F0, 1, 0, 8'(i), 1);
      step("R1", 16'h03F1, 0, 1, 8'h00, 1);
    end
    // R4 and R5: every index, one write and one read back (index-port read)
    for (int i = 0; i < 256; i++) begin
      step("R2", 16'h03F0, 1, 0, 8'(i), 1);
      step("R4_R5", 16'h03F1, 1, 0, 8'(i) ^ 8'h5A, 1);
      step("R3", 16'h03F0, 0, 1, 8'h00, 1);
    end
    // R6: serial base registers
    step("R2", 16'h03F0, 1, 0, 8'hE7, 1);
    step("R6", 16'h03F1, 1, 0, 8'h00, 1);
    step("R6", 16'h03F1, 0, 1, 8'h00, 1);
    step("R6", 16'h03F1, 1, 0, 8'hFE, 1);
    step("R6", 16'h03F1, 0, 1, 8'h00, 1);
    step("R2", 16'h03F0, 1, 0, 8'hE8, 1);
    step("R6", 16'h03F1, 1, 0, 8'hFE, 1);
    step("R6", 16'h03F1, 0, 1, 8'h00, 1);
    step("R6", 16'h03F1, 1, 0, 8'hBE, 1);
    step("R6", 16'h03F1, 0, 1, 8'h00, 1);
    // R8: a read and a write in the same cycle
    step("R2", 16'h03F0, 1, 0, 8'hE1, 1);
    step("R8", 16'h03F1, 1, 1, 8'h77, 1);
    step("R8", 16'h03F1, 0, 1, 8'h00, 1);
    // R7: window closed
    step("R7", 16'h03F0, 1, 0, 8'hE2, 0);
    step("R7", 16'h03F1, 1, 0, 8'h11, 0);
    step("R7", 16'h03F1, 0, 1, 8'h00, 0);
    step("R7", 16'h03F0, 0, 1, 8'h00, 0);
    step("R7", 16'h03F1, 0, 1, 8'h00, 1);
    // R9: foreign addresses
    step("R9", 16'h03F2, 1, 0, 8'hEE, 1);
    step("R9", 16'h02F0, 1, 0, 8'hEF, 1);
    step("R9", 16'h13F1, 1, 0, 8'h99, 1);
    step("R9", 16'h03F2, 0, 1, 8'h00, 1);
    step("R9", 16'h03F1, 0, 1, 8'h00, 1);
    // R3: back-to-back reads give back-to-back valid cycles
    step("R3", 16'h03F1, 0, 1, 8'h00, 1);
    step("R3", 16'h03F0, 0, 1, 8'h00, 1);
    step("R3", 16'h03F1, 0, 0, 8'h00, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule